// File: doc/BRIEF.md
# Multichannel Time-Multiplexed FIR Filter

This block is a single-rate finite impulse response filter that serves several independent data channels through one shared multiply-accumulate datapath. Every incoming sample carries a valid flag and a time-slot tag. A run-time mode input picks one row of a parameter table. That row translates the slot tag into the logical channel whose tap history the sample extends. Each logical channel keeps its own history, so interleaved streams never mix.

The coefficients are assumed to be mirror-symmetric or mirror-antisymmetric, chosen by a parameter. Only half of them are stored. Before each multiply the datapath adds (symmetric) or subtracts (antisymmetric) the two samples that share a coefficient, so only half as many multipliers are needed. Two coefficient sets can be held, and a bank-select input chooses between them for each sample. A host port maps the stored coefficients into a small address window. A parameter makes that window read/write, read-only, write-only or constant. The result is kept at full precision and leaves with its own valid flag and channel tag.

Top module: `tdm_fir`

## Requirements
- R1: A synchronous reset (`rst` high at a rising edge) clears every channel history to zero and drops `outValid`. It leaves the coefficient registers unchanged, so they read back their old values after reset.
- R2: A sample accepted at a rising edge (`inValid` high) gives exactly one result with `outValid` high after the third rising edge, counting the accepting edge as the first. `outValid` is low in every cycle that has no such result.
- R3: `outData` is signed, `DATA_W + COEF_W + clog2(TAPS)` bits wide (18 by default), and holds the exact sum with no rounding or saturation, even when every sample and coefficient is the most negative value.
- R4: With `ANTI_SYM = 0` the result is the sum over k < TAPS/2 of h[k]·(x[k] + x[TAPS-1-k]). Here x[0] is the newest sample of the channel and x[j] is its j-th predecessor.
- R5: With `ANTI_SYM = 1` the result is the sum over k < TAPS/2 of h[k]·(x[k] − x[TAPS-1-k]).
- R6: Each logical channel has its own history of the last TAPS−1 accepted samples. A sample shifts only its own channel's history. Cycles with `inValid` low change no history, whatever `inData` holds.
- R7: The logical channel is entry `mode*NCH + inSlot` of `CHAN_MAP`, each entry CH_W bits wide with entry 0 in the low bits. The default table maps mode 0 slots 0,1,2,3 to channels 0,1,2,3, and mode 1 slots 0,1,2,3 to channels 1,1,3,0. `outChan` carries that logical channel with its result.
- R8: `bankSel` sampled with the input chooses coefficient set b, made of stored entries b*TAPS/2 through b*TAPS/2 + TAPS/2 − 1. Entry index b*TAPS/2 + k holds h[k] of set b.
- R9: When writes are allowed (read/write or write-only), a write with `hostWrEn` to address `BASE + i` stores `hostWrData` in entry i, for 0 ≤ i < BANKS*TAPS/2. Writes to other addresses change no entry.
- R10: A read with `hostRdEn` returns its data on `hostRdData` after the next rising edge. Addresses outside the window, and every read when reads are not allowed, return zero.
- R11: With `ACCESS` set to read-only (1) or constant (0), the entries are the values in `COEF_INIT` and host writes are ignored. In read-only mode those values are readable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| inValid | input | 1 | Input sample is valid |
| inData | input | DATA_W | Signed input sample |
| inSlot | input | CH_W | Time-slot tag of the input sample |
| mode | input | MODE_W | Row of the slot-to-channel table |
| bankSel | input | BANK_W | Coefficient set for this sample |
| hostAddr | input | ADDR_W | Host address |
| hostWrEn | input | 1 | Host write strobe |
| hostWrData | input | COEF_W | Host write data |
| hostRdEn | input | 1 | Host read strobe |
| hostRdData | output | COEF_W | Host read data, one cycle after the strobe |
| outValid | output | 1 | Result is valid |
| outChan | output | CH_W | Logical channel of the result |
| outData | output | OUT_W | Signed full-precision result |

## Verification
A filter result is due after the third rising edge, counting the one that accepts the sample. A host read result is due after the single edge that samples the strobe. The bench drives on falling edges and keeps a two-deep queue of expected results. At each falling edge it compares the outputs with the entry made two steps earlier. Every cycle of every phase, idle and reset cycles included, is therefore checked against the exact cycle its result is due. A reset flushes the queue, because the design discards results still in flight. Host reads are compared at the falling edge right after their strobe edge, and only once the filter pipeline has drained.

// File: rtl/tdm_fir_pkg.sv
package tdm_fir_pkg;

  // strobes from the control path into the datapath, one per pipeline stage
  typedef struct packed {
    logic shiftEn;  // accept a sample, shift the selected history
    logic prodEn;   // load the pre-add products
    logic sumEn;    // load the summed result
  } fir_strobe_t;

  // host access kinds for the coefficient window
  localparam int ACC_CONST = 0;
  localparam int ACC_RO    = 1;
  localparam int ACC_WO    = 2;
  localparam int ACC_RW    = 3;

endpackage

// File: rtl/tdm_fir_ctrl.sv
module tdm_fir_ctrl
  import tdm_fir_pkg::*;
#(
  parameter int NCH    = 4,
  parameter int NMODES = 2,
  parameter int CH_W   = 2,
  parameter int MODE_W = 1,
  parameter int BANK_W = 1,
  parameter logic [NMODES*NCH*CH_W-1:0] CHAN_MAP = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              inValid,
  input  logic [CH_W-1:0]   inSlot,
  input  logic [MODE_W-1:0] mode,
  input  logic [BANK_W-1:0] bankSel,
  output fir_strobe_t       strobe,
  output logic [CH_W-1:0]   histChan,
  output logic [BANK_W-1:0] prodBank,
  output logic              outValid,
  output logic [CH_W-1:0]   outChan
);

  int mapRow;
  logic validS1, validS2;
  logic [CH_W-1:0] chanS1, chanS2;
  logic [1:0] sinceRst;

  // slot tag -> logical channel through the selected table row
  always_comb begin
    mapRow   = (int'(mode) < NMODES) ? int'(mode) : 0;
    histChan = CHAN_MAP[(mapRow*NCH + int'(inSlot))*CH_W +: CH_W];
  end

  always_comb begin
    strobe.shiftEn = inValid;
    strobe.prodEn  = validS1;
    strobe.sumEn   = validS2;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      validS1  <= 1'b0;
      validS2  <= 1'b0;
      outValid <= 1'b0;
      sinceRst <= '0;
    end else begin
      validS1  <= inValid;
      validS2  <= validS1;
      outValid <= validS2;
      if (sinceRst != 2'd3) sinceRst <= sinceRst + 2'd1;
    end
  end

  always_ff @(posedge clk) begin
    chanS1   <= histChan;
    chanS2   <= chanS1;
    outChan  <= chanS2;
    prodBank <= bankSel;
  end

  // R1
  reset_flush_chk: assert property (@(posedge clk) rst |=> !outValid);

  // R2
  valid_latency_chk: assert property (@(posedge clk) disable iff (rst)
    (sinceRst == 2'd3) |-> (outValid == $past(inValid, 3)));

  // R7
  chan_tag_chk: assert property (@(posedge clk) disable iff (rst)
    (sinceRst == 2'd3 && outValid) |-> (outChan == $past(histChan, 3)));

endmodule

// File: rtl/tdm_fir_coef.sv
module tdm_fir_coef
  import tdm_fir_pkg::*;
#(
  parameter int COEF_W = 8,
  parameter int NCOEF  = 4,
  parameter int ADDR_W = 8,
  parameter int BASE   = 16,
  parameter int ACCESS = ACC_RW,
  parameter logic [NCOEF*COEF_W-1:0] COEF_INIT = '0
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [ADDR_W-1:0]       hostAddr,
  input  logic                    hostWrEn,
  input  logic [COEF_W-1:0]       hostWrData,
  input  logic                    hostRdEn,
  output logic [COEF_W-1:0]       hostRdData,
  output logic [NCOEF*COEF_W-1:0] coefFlat
);

  localparam logic [ADDR_W-1:0] BASE_A = ADDR_W'(BASE);
  localparam logic [ADDR_W-1:0] SPAN_A = ADDR_W'(NCOEF);
  localparam int  IDX_W    = (NCOEF > 1) ? $clog2(NCOEF) : 1;
  localparam bit  WRITABLE = (ACCESS == ACC_RW) || (ACCESS == ACC_WO);
  localparam bit  READABLE = (ACCESS == ACC_RW) || (ACCESS == ACC_RO);

  logic [ADDR_W-1:0] offset;
  logic              inRange;
  logic [IDX_W-1:0]  idx;

  always_comb begin
    offset  = hostAddr - BASE_A;
    inRange = (hostAddr >= BASE_A) && (offset < SPAN_A);
    idx     = offset[IDX_W-1:0];
  end

  generate
    if (WRITABLE) begin : g_regs
      logic [COEF_W-1:0] coefReg [NCOEF];
      // no reset: coefficients survive a filter reset
      always_ff @(posedge clk) begin
        if (hostWrEn && inRange) coefReg[idx] <= hostWrData;
      end
      for (genvar i = 0; i < NCOEF; i++) begin : g_flat
        assign coefFlat[i*COEF_W +: COEF_W] = coefReg[i];
      end
    end else begin : g_const
      assign coefFlat = COEF_INIT;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) hostRdData <= '0;
    else if (hostRdEn)
      hostRdData <= (READABLE && inRange) ? coefFlat[int'(idx)*COEF_W +: COEF_W] : '0;
  end

  // R10
  oor_read_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (hostRdEn && !inRange) |=> (hostRdData == '0));

  // R9
  coef_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !hostWrEn |=> $stable(coefFlat));

endmodule

// File: rtl/tdm_fir_dp.sv
module tdm_fir_dp
  import tdm_fir_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int COEF_W   = 8,
  parameter int TAPS     = 4,
  parameter int NCH      = 4,
  parameter int BANKS    = 2,
  parameter int CH_W     = 2,
  parameter int BANK_W   = 1,
  parameter int ANTI_SYM = 0,
  parameter int OUT_W    = 18
) (
  input  logic                             clk,
  input  logic                             rst,
  input  fir_strobe_t                      strobe,
  input  logic signed [DATA_W-1:0]         inData,
  input  logic [CH_W-1:0]                  histChan,
  input  logic [BANK_W-1:0]                prodBank,
  input  logic [BANKS*(TAPS/2)*COEF_W-1:0] coefFlat,
  output logic signed [OUT_W-1:0]          outData
);

  localparam int UNIQ   = TAPS / 2;
  localparam int PRE_W  = DATA_W + 1;
  localparam int PROD_W = PRE_W + COEF_W;

  logic signed [DATA_W-1:0] hist   [NCH][TAPS-1];
  logic signed [DATA_W-1:0] win    [TAPS];
  logic signed [DATA_W-1:0] winReg [TAPS];
  logic signed [PROD_W-1:0] prod   [UNIQ];
  logic signed [OUT_W-1:0]  acc;
  int bankIdx;

  always_comb begin
    win[0] = inData;
    for (int k = 1; k < TAPS; k++) win[k] = hist[histChan][k-1];
    bankIdx = (int'(prodBank) < BANKS) ? int'(prodBank) : 0;
  end

  // stage 1: per-channel history shift and window capture
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int c = 0; c < NCH; c++)
        for (int k = 0; k < TAPS-1; k++) hist[c][k] <= '0;
    end else if (strobe.shiftEn) begin
      hist[histChan][0] <= inData;
      for (int k = 1; k < TAPS-1; k++) hist[histChan][k] <= hist[histChan][k-1];
    end
  end

  always_ff @(posedge clk) begin
    if (strobe.shiftEn)
      for (int k = 0; k < TAPS; k++) winReg[k] <= win[k];
  end

  // stage 2: mirrored pre-add (or pre-subtract) and multiply
  generate
    for (genvar k = 0; k < UNIQ; k++) begin : g_tap
      logic signed [PRE_W-1:0]  pre;
      logic signed [COEF_W-1:0] cf;
      if (ANTI_SYM != 0) begin : g_anti
        assign pre = PRE_W'(winReg[k]) - PRE_W'(winReg[TAPS-1-k]);
      end else begin : g_sym
        assign pre = PRE_W'(winReg[k]) + PRE_W'(winReg[TAPS-1-k]);
      end
      assign cf = coefFlat[(bankIdx*UNIQ + k)*COEF_W +: COEF_W];
      always_ff @(posedge clk) begin
        if (strobe.prodEn) prod[k] <= PROD_W'(pre) * PROD_W'(cf);
      end
    end
  endgenerate

  // stage 3: full-precision sum
  always_comb begin
    acc = '0;
    for (int k = 0; k < UNIQ; k++) acc = acc + OUT_W'(prod[k]);
  end

  always_ff @(posedge clk) begin
    if (strobe.sumEn) outData <= acc;
  end

  // R6
  window_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !strobe.shiftEn |=> $stable(winReg[0]));

endmodule

// File: rtl/tdm_fir.sv
module tdm_fir
  import tdm_fir_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int COEF_W   = 8,
  parameter int TAPS     = 4,
  parameter int NCH      = 4,
  parameter int NMODES   = 2,
  parameter int BANKS    = 2,
  parameter int ANTI_SYM = 0,
  parameter int ACCESS   = ACC_RW,
  parameter int ADDR_W   = 8,
  parameter int BASE     = 16,
  parameter logic [NMODES*NCH*((NCH > 1) ? $clog2(NCH) : 1)-1:0] CHAN_MAP = 16'h35E4,
  parameter logic [BANKS*(TAPS/2)*COEF_W-1:0] COEF_INIT = 32'h0705FE03,
  localparam int CH_W   = (NCH > 1) ? $clog2(NCH) : 1,
  localparam int MODE_W = (NMODES > 1) ? $clog2(NMODES) : 1,
  localparam int BANK_W = (BANKS > 1) ? $clog2(BANKS) : 1,
  localparam int OUT_W  = DATA_W + COEF_W + $clog2(TAPS)
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     inValid,
  input  logic [DATA_W-1:0]        inData,
  input  logic [CH_W-1:0]          inSlot,
  input  logic [MODE_W-1:0]        mode,
  input  logic [BANK_W-1:0]        bankSel,
  input  logic [ADDR_W-1:0]        hostAddr,
  input  logic                     hostWrEn,
  input  logic [COEF_W-1:0]        hostWrData,
  input  logic                     hostRdEn,
  output logic [COEF_W-1:0]        hostRdData,
  output logic                     outValid,
  output logic [CH_W-1:0]          outChan,
  output logic [OUT_W-1:0]         outData
);

  localparam int NCOEF = BANKS * (TAPS / 2);

  fir_strobe_t              strobe;
  logic [CH_W-1:0]          histChan;
  logic [BANK_W-1:0]        prodBank;
  logic [NCOEF*COEF_W-1:0]  coefFlat;
  logic signed [OUT_W-1:0]  dpOut;

  tdm_fir_ctrl #(
    .NCH(NCH), .NMODES(NMODES), .CH_W(CH_W), .MODE_W(MODE_W),
    .BANK_W(BANK_W), .CHAN_MAP(CHAN_MAP)
  ) i_ctrl (
    .clk(clk), .rst(rst), .inValid(inValid), .inSlot(inSlot), .mode(mode),
    .bankSel(bankSel), .strobe(strobe), .histChan(histChan),
    .prodBank(prodBank), .outValid(outValid), .outChan(outChan)
  );

  tdm_fir_coef #(
    .COEF_W(COEF_W), .NCOEF(NCOEF), .ADDR_W(ADDR_W), .BASE(BASE),
    .ACCESS(ACCESS), .COEF_INIT(COEF_INIT)
  ) i_coef (
    .clk(clk), .rst(rst), .hostAddr(hostAddr), .hostWrEn(hostWrEn),
    .hostWrData(hostWrData), .hostRdEn(hostRdEn), .hostRdData(hostRdData),
    .coefFlat(coefFlat)
  );

  tdm_fir_dp #(
    .DATA_W(DATA_W), .COEF_W(COEF_W), .TAPS(TAPS), .NCH(NCH), .BANKS(BANKS),
    .CH_W(CH_W), .BANK_W(BANK_W), .ANTI_SYM(ANTI_SYM), .OUT_W(OUT_W)
  ) i_dp (
    .clk(clk), .rst(rst), .strobe(strobe), .inData(inData),
    .histChan(histChan), .prodBank(prodBank), .coefFlat(coefFlat),
    .outData(dpOut)
  );

  assign outData = dpOut;

endmodule

// File: tb/test_tdm_fir.sv
`timescale 1ns/1ps
module test_tdm_fir;

  logic        clk = 1'b0;
  logic        rst, inValid, hostWrEn, hostRdEn;
  logic [7:0]  inData, hostAddr, hostWrData;
  logic [1:0]  inSlot;
  logic        mode, bankSel;
  logic [7:0]  rdData0, rdData1;
  logic        outValid0, outValid1;
  logic [1:0]  outChan0, outChan1;
  logic [17:0] outData0, outData1;

  always #2.5 clk = ~clk;

  tdm_fir i_tdm_fir (
    .clk(clk), .rst(rst), .inValid(inValid), .inData(inData), .inSlot(inSlot),
    .mode(mode), .bankSel(bankSel), .hostAddr(hostAddr), .hostWrEn(hostWrEn),
    .hostWrData(hostWrData), .hostRdEn(hostRdEn), .hostRdData(rdData0),
    .outValid(outValid0), .outChan(outChan0), .outData(outData0)
  );

  tdm_fir #(.ANTI_SYM(1), .ACCESS(1)) i_tdm_fir_anti (
    .clk(clk), .rst(rst), .inValid(inValid), .inData(inData), .inSlot(inSlot),
    .mode(mode), .bankSel(bankSel), .hostAddr(hostAddr), .hostWrEn(hostWrEn),
    .hostWrData(hostWrData), .hostRdEn(hostRdEn), .hostRdData(rdData1),
    .outValid(outValid1), .outChan(outChan1), .outData(outData1)
  );

  typedef struct { bit v; int ch; int d0; int d1; } exp_t;

  int    vectors = 0, errors = 0;
  bit    finished = 1'b0;
  string curReq = "R1";
  int    hist [4][3];
  int    cw [2][2];                       // read/write instance coefficients
  int    cr [2][2] = '{'{3, -2}, '{5, 7}}; // read-only instance initial values
  exp_t  h1, h2;

  function automatic int mapCh(int md, int slot);
    int row1 [4] = '{1, 1, 3, 0};
    return (md == 0) ? slot : row1[slot];
  endfunction

  task automatic check(string what, int act, int expv);
    vectors++;
    if (act != expv) begin
      errors++;
      $display("FAIL %s %s: got %0d expected %0d", curReq, what, act, expv);
    end
  endtask

  task automatic compare(exp_t e);
    check("outValid sym", int'(outValid0), int'(e.v));
    check("outValid anti", int'(outValid1), int'(e.v));
    if (e.v) begin
      check("outChan sym", int'(outChan0), e.ch);
      check("outChan anti", int'(outChan1), e.ch);
      check("outData sym", int'($signed(outData0)), e.d0);
      check("outData anti", int'($signed(outData1)), e.d1);
    end
  endtask

  task automatic step(bit r, bit v, int data, int slot, int md, int bk);
    exp_t e;
    int   w [4];
    rst = r; inValid = v; inData = 8'(data); inSlot = 2'(slot);
    mode = 1'(md); bankSel = 1'(bk);
    e = '{v: 1'b0, ch: 0, d0: 0, d1: 0};
    if (r) begin
      foreach (hist[c, k]) hist[c][k] = 0;
      h1.v = 1'b0; h2.v = 1'b0;
    end else if (v) begin
      e.ch = mapCh(md, slot);
      w[0] = data;
      for (int k = 1; k < 4; k++) w[k] = hist[e.ch][k-1];
      e.d0 = cw[bk][0]*(w[0]+w[3]) + cw[bk][1]*(w[1]+w[2]);
      e.d1 = cr[bk][0]*(w[0]-w[3]) + cr[bk][1]*(w[1]-w[2]);
      hist[e.ch][2] = hist[e.ch][1];
      hist[e.ch][1] = hist[e.ch][0];
      hist[e.ch][0] = data;
      e.v = 1'b1;
    end
    @(negedge clk);
    compare(h2);
    h2 = h1;
    h1 = e;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, 0);
  endtask

  task automatic hostWrite(int addr, int val);
    hostAddr = 8'(addr); hostWrData = 8'(val); hostWrEn = 1'b1;
    @(negedge clk);
    hostWrEn = 1'b0;
    if (addr >= 16 && addr < 20) cw[(addr-16)/2][(addr-16)%2] = val;
  endtask

  task automatic hostRead(int addr);
    int e0, e1;
    e0 = (addr >= 16 && addr < 20) ? cw[(addr-16)/2][(addr-16)%2] : 0;
    e1 = (addr >= 16 && addr < 20) ? cr[(addr-16)/2][(addr-16)%2] : 0;
    hostAddr = 8'(addr); hostRdEn = 1'b1;
    @(negedge clk);
    hostRdEn = 1'b0;
    check("hostRdData rw", int'($signed(rdData0)), e0);
    check("hostRdData ro", int'($signed(rdData1)), e1);
  endtask

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    int r;
    r = $urandom(32'd1234);
    h1 = '{v: 1'b0, ch: 0, d0: 0, d1: 0};
    h2 = h1;
    rst = 1'b1; inValid = 1'b0; inData = '0; inSlot = '0; mode = 1'b0;
    bankSel = 1'b0; hostAddr = '0; hostWrEn = 1'b0; hostWrData = '0; hostRdEn = 1'b0;
    @(negedge clk);

    // R1: reset state, no valid output
    curReq = "R1";
    for (int i = 0; i < 3; i++) step(1, 1, 5, 0, 0, 0);
    idle(3);

    // R9: program both banks, stray writes outside the window
    curReq = "R9";
    hostWrite(16, 4); hostWrite(17, -3); hostWrite(18, -7); hostWrite(19, 2);
    hostWrite(15, 99); hostWrite(20, 55);
    for (int a = 16; a < 20; a++) hostRead(a);
    // R10: out-of-window reads give zero
    curReq = "R10";
    hostRead(15); hostRead(20); hostRead(255); hostRead(0);
    // R11: read-only copy ignored the writes and shows its initial values
    curReq = "R11";
    hostRead(16); hostRead(19);

    // R4 R5: impulse on slot 2
    curReq = "R4 R5";
    step(0, 1, 1, 2, 0, 0);
    for (int i = 0; i < 4; i++) step(0, 1, 0, 2, 0, 0);
    step(0, 1, -9, 2, 0, 0); step(0, 1, 13, 2, 0, 0);
    idle(3);

    // R6: interleaved channels with invalid cycles carrying garbage
    curReq = "R6";
    step(0, 1, 10, 0, 0, 0); step(0, 1, -5, 1, 0, 0);
    step(0, 0, 77, 0, 0, 0); step(0, 0, -77, 1, 0, 1);
    step(0, 1, 20, 0, 0, 0); step(0, 0, 33, 0, 0, 0);
    step(0, 1, 30, 0, 0, 0); step(0, 1, 6, 1, 0, 0);
    idle(3);

    // R7: alternate schedule, two slots sharing one history
    curReq = "R7";
    for (int p = 0; p < 3; p++)
      for (int s = 0; s < 4; s++) step(0, 1, 7*s - 11*p + 3, s, 1, 0);
    idle(3);

    // R8: second coefficient set
    curReq = "R8";
    for (int i = 0; i < 6; i++) step(0, 1, 17*i - 40, 3, 0, 1);
    for (int i = 0; i < 4; i++) step(0, 1, 9 - 5*i, 3, 0, i % 2);
    idle(3);

    // R1: reset mid-stream flushes results and histories, keeps coefficients
    curReq = "R1";
    step(0, 1, 50, 1, 0, 0); step(0, 1, 60, 1, 0, 0);
    step(1, 0, 0, 0, 0, 0); step(1, 0, 0, 0, 0, 0);
    idle(3);
    for (int a = 16; a < 20; a++) hostRead(a);
    step(0, 1, 70, 1, 0, 0); step(0, 1, 1, 1, 0, 0);
    idle(3);

    // R3: extreme values, full precision
    curReq = "R3";
    hostWrite(18, -128); hostWrite(19, -128);
    for (int i = 0; i < 5; i++) step(0, 1, -128, 3, 0, 1);
    for (int i = 0; i < 5; i++) step(0, 1, 127, 2, 0, 1);
    idle(3);
    hostWrite(18, 127); hostWrite(19, -128);

    // R2: constrained random traffic, every result checked at its due cycle
    curReq = "R2";
    for (int i = 0; i < 600; i++) begin
      int d, pick;
      pick = int'($urandom_range(0, 7));
      d = (pick == 0) ? -128 : (pick == 1) ? 127 : int'($urandom_range(0, 255)) - 128;
      step(0, $urandom_range(0, 9) < 7, d, int'($urandom_range(0, 3)),
           int'($urandom_range(0, 1)), int'($urandom_range(0, 1)));
    end
    idle(3);

    finished = 1'b1;
    summary();
    $finish;
  end

endmodule